// File: doc/BRIEF.md
# Audio Master Clock Generator

This block produces the two clocks of a serial audio port that is clock master: a frame clock at the sample rate and a bit clock at 64 times the sample rate. Both come from one external master clock. A 3-bit prescaler field and a 2-bit speed field select the ratio. The master clock is first divided by 1, 1.5, 2, 3 or 4. The result is then divided by 256, 128 or 64 to give the frame clock, and by 4, 2 or 1 to give the bit clock. The bit clock therefore stays at 64 periods per frame in every setting.

The fractional prescaler uses both master-clock edges. All timing is counted in half-periods of the master clock. Each output is built from a rising-edge register XORed with a falling-edge register, so an output moves on whichever edge its schedule calls for, and only one of the two registers changes at any edge. There is no data stream here. The two configuration fields are plain level inputs, and the three outputs are plain levels with no handshake.

A setting that is not legal raises an error flag and holds both clocks low. Changing either field restarts the frame from its beginning.

Top module: `audio_mclk_gen`

## Requirements
- R1: Prescaler field `pre_sel` codes 0, 1, 2, 3 and 4 select division of the master clock by 1, 1.5, 2, 3 and 4. With a legal speed code, these codes keep `cfg_err` low.
- R2: Speed field `spd_sel` code 0 makes one frame (one `lrck` period) last 256 prescaled clocks, code 1 makes it last 128, and code 2 makes it last 64. One frame therefore lasts 128·P·K master-clock half-periods, where P is the prescale ratio and K = 4, 2 or 1 for speed codes 0, 1 and 2.
- R3: The `sclk` period is H = 2·P·K master-clock half-periods, and every frame holds exactly 64 `sclk` periods.
- R4: `lrck` is low for the first (left) half of each frame and high for the second (right) half. It changes only at a falling edge of `sclk`: the falling edges of bit periods 31 and 63.
- R5: Within each `sclk` period, `sclk` is high for the first floor(H/2) half-periods and low for the rest. This covers odd H (prescale 1.5 in quad speed gives H = 3, high for one half-period and low for two), and the edges then fall on both master-clock edges.
- R6: At the first rising edge of `mclk` that samples `pre_sel` of 5 to 7 or `spd_sel` of 3, `cfg_err` goes high, and `sclk` and `lrck` go low and stay low while the setting remains illegal.
- R7: Any rising edge that samples a setting different from the one sampled at the previous rising edge is a restart edge: the outputs go low there. `sclk` rises at the next rising edge, which begins bit 0 of the left half. Rewriting the same setting has no effect.
- R8: While `rst_n` is low, `sclk`, `lrck` and `cfg_err` are low. The first rising edge after release is a restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | External master clock; both edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| pre_sel | input | 3 | Prescaler select |
| spd_sel | input | 2 | Speed-mode select |
| lrck | output | 1 | Frame clock; low marks the left channel |
| sclk | output | 1 | Serial bit clock, 64 per frame |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The bench builds the block with its default of 64 bit clocks per frame. It checks both outputs after every rising and every falling master-clock edge against a model that counts half-periods.

These defaults bring every legal prescaler and speed combination within reach, each for two whole frames. That covers the smallest odd bit period of three half-periods, the longest frame of 2048 half-periods, and frame-clock transitions that land on falling master-clock edges.

Illegal codes, a mid-frame change of setting, a rewrite of the same setting and a reset in the middle of a frame are also driven.

// File: rtl/amg_pkg.sv
package amg_pkg;
  localparam int PRE_W = 3;
  localparam int SPD_W = 2;
  // widest bit period: prescale 4 (8 half units) times speed factor 4 = 32
  localparam int PH_W  = 6;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [SPD_W-1:0] spd;
  } amg_cfg_t;

  // prescale ratio expressed in master-clock half-periods (0 = illegal)
  function automatic logic [3:0] pre_half_units(input logic [PRE_W-1:0] code);
    case (code)
      3'd0:    return 4'd2;
      3'd1:    return 4'd3;
      3'd2:    return 4'd4;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  // prescaled clocks per bit clock (0 = illegal)
  function automatic logic [2:0] spd_factor(input logic [SPD_W-1:0] code);
    case (code)
      2'd0:    return 3'd4;
      2'd1:    return 3'd2;
      2'd2:    return 3'd1;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/amg_decode.sv
module amg_decode
  import amg_pkg::*;
(
  input  amg_cfg_t        cfg,
  output logic            legal,
  output logic [PH_W-1:0] h_len,
  output logic [PH_W-1:0] h_high
);
  logic [3:0] p_units;
  logic [2:0] s_mult;
  logic [6:0] prod;

  always_comb begin
    p_units = pre_half_units(cfg.pre);
    s_mult  = spd_factor(cfg.spd);
    legal   = (p_units != 4'd0) && (s_mult != 3'd0);
    prod    = 7'(p_units) * 7'(s_mult);
    h_len   = legal ? prod[PH_W-1:0] : PH_W'(2);
    h_high  = h_len >> 1;
  end
endmodule

// File: rtl/amg_phase.sv
module amg_phase
  import amg_pkg::*;
#(
  parameter int SCLK_PER_FRAME = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  amg_cfg_t        cfg,
  input  logic            legal,
  input  logic [PH_W-1:0] h_len,
  input  logic [PH_W-1:0] h_high,
  output logic [1:0]      pos_tgt,
  output logic [1:0]      neg_tgt_q,
  output logic            err_q
);
  localparam int K_W  = $clog2(SCLK_PER_FRAME);
  localparam int HALF = SCLK_PER_FRAME / 2;
  localparam logic [K_W-1:0] K_LAST = K_W'(SCLK_PER_FRAME - 1);
  localparam logic [K_W-1:0] K_MID  = K_W'(HALF - 1);

  logic [PH_W-1:0] q_q, q1, q2;
  logic [K_W-1:0]  k_q, k1, k2;
  amg_cfg_t        cfg_q;
  logic            fresh_q;
  logic            restart;
  logic            s0, s1, l0, l1;

  function automatic logic frame_level(input logic [PH_W-1:0] q,
                                       input logic [K_W-1:0]  k,
                                       input logic [PH_W-1:0] hh);
    return ((k > K_MID) && (k < K_LAST)) ||
           ((k == K_MID) && (q >= hh)) ||
           ((k == K_LAST) && (q < hh));
  endfunction

  always_comb begin
    restart = fresh_q || !legal || (cfg != cfg_q);
    // half-period at this rising edge
    s0 = (q_q < h_high);
    l0 = frame_level(q_q, k_q, h_high);
    // following half-period (falling edge)
    if (q_q + PH_W'(1) == h_len) begin
      q1 = '0;
      k1 = (k_q == K_LAST) ? '0 : k_q + K_W'(1);
    end else begin
      q1 = q_q + PH_W'(1);
      k1 = k_q;
    end
    s1 = (q1 < h_high);
    l1 = frame_level(q1, k1, h_high);
    // position for the next rising edge
    if (q1 + PH_W'(1) == h_len) begin
      q2 = '0;
      k2 = (k1 == K_LAST) ? '0 : k1 + K_W'(1);
    end else begin
      q2 = q1 + PH_W'(1);
      k2 = k1;
    end
    pos_tgt = restart ? 2'b00 : {l0, s0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q       <= '0;
      k_q       <= '0;
      cfg_q     <= '0;
      fresh_q   <= 1'b1;
      err_q     <= 1'b0;
      neg_tgt_q <= 2'b00;
    end else begin
      fresh_q <= 1'b0;
      cfg_q   <= cfg;
      err_q   <= !legal;
      if (restart) begin
        q_q       <= '0;
        k_q       <= '0;
        neg_tgt_q <= 2'b00;
      end else begin
        q_q       <= q2;
        k_q       <= k2;
        neg_tgt_q <= {l1, s1};
      end
    end
  end

  // R3: phase counter stays inside the current bit period
  p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> (q_q < h_len));

  // R7: a restart edge returns the frame position to its origin
  p_restart_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (q_q == '0 && k_q == '0));

  // R4: frame clock moves between falling half and this edge only on a bit-clock fall
  p_lrck_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (l0 != neg_tgt_q[1])) |-> (neg_tgt_q[0] && !s0));

  // R4: frame clock moves between this edge and the falling edge only on a bit-clock fall
  p_lrck_on_fall_neg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && (l1 != l0)) |-> (s0 && !s1));
endmodule

// File: rtl/amg_dual_edge.sv
module amg_dual_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_val,
  input  logic neg_val,
  output logic q
);
  logic tp_q, tn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tp_q <= 1'b0;
    else        tp_q <= pos_val ^ tn_q;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) tn_q <= 1'b0;
    else        tn_q <= neg_val ^ tp_q;
  end

  assign q = tp_q ^ tn_q;
endmodule

// File: rtl/audio_mclk_gen.sv
module audio_mclk_gen
  import amg_pkg::*;
#(
  parameter int SCLK_PER_FRAME = 64
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_sel,
  input  logic [SPD_W-1:0] spd_sel,
  output logic             lrck,
  output logic             sclk,
  output logic             cfg_err
);
  amg_cfg_t        cfg;
  logic            legal;
  logic [PH_W-1:0] h_len, h_high;
  logic [1:0]      pos_tgt, neg_tgt;
  logic [1:0]      outs;

  assign cfg.pre = pre_sel;
  assign cfg.spd = spd_sel;

  amg_decode u_dec (
    .cfg    (cfg),
    .legal  (legal),
    .h_len  (h_len),
    .h_high (h_high)
  );

  amg_phase #(.SCLK_PER_FRAME(SCLK_PER_FRAME)) u_phase (
    .clk       (mclk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .legal     (legal),
    .h_len     (h_len),
    .h_high    (h_high),
    .pos_tgt   (pos_tgt),
    .neg_tgt_q (neg_tgt),
    .err_q     (cfg_err)
  );

  // bit 0 = bit clock, bit 1 = frame clock
  for (genvar i = 0; i < 2; i++) begin : g_out
    amg_dual_edge u_de (
      .clk     (mclk),
      .rst_n   (rst_n),
      .pos_val (pos_tgt[i]),
      .neg_val (neg_tgt[i]),
      .q       (outs[i])
    );
  end

  assign sclk = outs[0];
  assign lrck = outs[1];

  // R6: an illegal setting keeps both clocks low
  p_err_quiet_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    cfg_err |-> (!sclk && !lrck));
endmodule

// File: tb/sim_audio_mclk_gen.sv
`timescale 1ns/1ps
module sim_audio_mclk_gen;
  localparam int FRAME_BITS = 64;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pre_sel = 3'd0;
  logic [1:0] spd_sel = 2'd0;
  logic       lrck, sclk, cfg_err;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 mclk = ~mclk;  // 200 MHz

  audio_mclk_gen #(.SCLK_PER_FRAME(FRAME_BITS)) u0 (
    .mclk(mclk), .rst_n(rst_n), .pre_sel(pre_sel), .spd_sel(spd_sel),
    .lrck(lrck), .sclk(sclk), .cfg_err(cfg_err)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: got %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int half_units(input int p);
    case (p)
      0: return 2; 1: return 3; 2: return 4; 3: return 6; 4: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int spd_mul(input int m);
    case (m)
      0: return 4; 1: return 2; 2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit sclk_at(input int n, input int h);
    return (n % h) < (h / 2);
  endfunction

  function automatic bit lrck_at(input int n, input int h);
    return ((n + h - h / 2) / ((FRAME_BITS / 2) * h)) % 2;
  endfunction

  // reference model: half-period counter
  bit fresh = 1;
  int prev_cfg = -1;
  int n = 0;
  bit e_ps, e_pl, e_ns, e_nl, e_err;
  string tag_s, tag_l, tag_e;

  initial begin
    forever begin
      @(posedge mclk);
      #1;
      if (!rst_n) begin
        fresh = 1; e_ps = 0; e_pl = 0; e_ns = 0; e_nl = 0; e_err = 0;
        tag_s = "R8"; tag_l = "R8"; tag_e = "R8";
      end else begin
        int p, m, h, cur;
        bit legal_c, rs;
        p = pre_sel; m = spd_sel;
        cur = p * 4 + m;
        legal_c = (half_units(p) != 0) && (spd_mul(m) != 0);
        rs = fresh || !legal_c || (cur != prev_cfg);
        e_err = !legal_c;
        if (!legal_c) begin
          tag_e = "R6"; tag_s = "R6"; tag_l = "R6";
        end else if (rs) begin
          tag_e = "R1"; tag_s = "R7"; tag_l = "R7";
        end else begin
          tag_e = "R1";
          tag_s = (p == 1) ? "R5" : "R3";
          tag_l = (n % 64 == 0) ? "R2" : "R4";
        end
        if (rs) begin
          e_ps = 0; e_pl = 0; e_ns = 0; e_nl = 0; n = 0;
        end else begin
          h = half_units(p) * spd_mul(m);
          e_ps = sclk_at(n, h);     e_pl = lrck_at(n, h);
          e_ns = sclk_at(n + 1, h); e_nl = lrck_at(n + 1, h);
          n = (n + 2) % (FRAME_BITS * h);
        end
        prev_cfg = cur;
        fresh = 0;
      end
      chk(tag_s, "sclk@rise", sclk, e_ps);
      chk(tag_l, "lrck@rise", lrck, e_pl);
      chk(tag_e, "cfg_err", cfg_err, e_err);
      @(negedge mclk);
      #1;
      if (!rst_n) begin e_ns = 0; e_nl = 0; end
      chk(tag_s, "sclk@fall", sclk, e_ns);
      chk(tag_l, "lrck@fall", lrck, e_nl);
    end
  end

  task automatic drive(input int p, input int m, input int cycles);
    @(negedge mclk); #2;
    pre_sel = 3'(p); spd_sel = 2'(m);
    repeat (cycles) @(posedge mclk);
  endtask

  initial begin
    // R8: reset state
    repeat (4) @(posedge mclk);
    @(negedge mclk); #2; rst_n = 1'b1;
    // R1 R2 R3 R4 R5: every legal combination for two frames
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 5; p++) begin
        drive(p, m, FRAME_BITS * half_units(p) * spd_mul(m) + 8);
      end
    end
    // R6: illegal codes
    drive(5, 0, 20);
    drive(7, 1, 20);
    drive(2, 3, 20);
    // R7: change mid-frame, then rewrite the same value
    drive(1, 2, 150);
    drive(3, 1, 300);
    drive(3, 1, 300);
    drive(0, 0, 700);
    // R8: reset in mid-frame
    @(negedge mclk); #2; rst_n = 1'b0;
    repeat (5) @(posedge mclk);
    @(negedge mclk); #2; rst_n = 1'b1;
    drive(1, 1, 500);
    @(negedge mclk); #2;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule